// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block adds or subtracts two operands of 8, 16 or 32 bits and derives six status
flags from the outcome: carry, parity, auxiliary carry, zero, sign and overflow. Every flag
follows the operand size picked on the current cycle. Operand bits above that size are
ignored. The result is returned masked to the chosen width.

The arithmetic itself is combinational. One register stage captures the result and all
flags, so a set of inputs presented before a rising clock edge shows up on the outputs
just after that edge. Subtraction treats the carry input as a borrow-in. The carry output
on a subtract is a true borrow, not the raw adder carry.

Top module: `asf_unit`

## Requirements
- R1: On add (`sub_i`=0), `res_o` equals (A + B + `cin_i`) modulo 2^w one clock after the inputs are sampled, where w is the selected width.
- R2: On subtract (`sub_i`=1), `res_o` equals (A − B − `cin_i`) modulo 2^w one clock later.
- R3: `size_i` encodes the width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Operand bits at or above w have no effect, and `res_o` bits at or above w read 0.
- R4: `cf_o` is the carry out of bit w−1 on add. On subtract it is 1 exactly when the subtrahend plus the borrow-in exceeds the minuend, unsigned, at width w.
- R5: `pf_o` is 1 when `res_o` holds an even number of one bits, and 0 otherwise.
- R6: `af_o` is the carry or borrow across the half-width boundary of the selected size: bit 3 into bit 4 for bytes, bit 7 into bit 8 for 16-bit words, and bit 15 into bit 16 for 32-bit operands.
- R7: `zf_o` is 1 exactly when `res_o` is zero.
- R8: `sf_o` equals bit w−1 of `res_o`.
- R9: `of_o` is 1 when the signed two's-complement result at width w falls outside the range of w bits. It is formed separately from the carry.
- R10: While `rst_n` is low, `res_o` reads 0, `zf_o` and `pf_o` read 1, and all other flags read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa_i | input | 32 | Operand A (minuend on subtract) |
| opb_i | input | 32 | Operand B (subtrahend on subtract) |
| cin_i | input | 1 | Carry-in on add, borrow-in on subtract |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| size_i | input | 2 | Operand width select |
| res_o | output | 32 | Registered result, zero above the width |
| cf_o | output | 1 | Carry / borrow flag |
| pf_o | output | 1 | Even-parity flag of the result |
| af_o | output | 1 | Half-width carry / borrow flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Signed overflow flag |

## Verification
The only state is the output register, so a fault always shows up one edge after the inputs that expose it. Examples are a carry tapped at the wrong width, a missing borrow inversion, or a mask that lets high bits through. Each of these corrupts `res_o` or a flag on the very next cycle. The bench therefore computes an integer-arithmetic model of every cycle's inputs and compares all seven outputs after each edge. The stimulus steers into the boundaries that separate the flags: signed limits, unsigned wrap, nibble/byte/half carries, and garbage above the width.

// File: rtl/asf_pkg.sv
package asf_pkg;

    localparam int unsigned ASF_W  = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_ALT   = 2'd3
    } op_size_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    function automatic int unsigned size_bits(op_size_e s);
        case (s)
            SZ_BYTE: return BYTE_W;
            SZ_WORD: return WORD_W;
            default: return ASF_W;
        endcase
    endfunction

    function automatic logic [ASF_W-1:0] width_mask(op_size_e s);
        logic [ASF_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < ASF_W; i++) begin
            if (i < size_bits(s)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/asf_operand_prep.sv
module asf_operand_prep
    import asf_pkg::*;
(
    input  logic [ASF_W-1:0] opa_i,
    input  logic [ASF_W-1:0] opb_i,
    input  logic             cin_i,
    input  logic             sub_i,
    input  op_size_e         size_i,
    output logic [ASF_W-1:0] a_o,
    output logic [ASF_W-1:0] b_o,
    output logic             c0_o
);
    logic [ASF_W-1:0] mask;

    always_comb begin
        mask = width_mask(size_i);
        a_o  = opa_i & mask;
        // subtract runs as A + ~B + ~borrow; inverted B stays inside the width
        b_o  = (sub_i ? ~opb_i : opb_i) & mask;
        c0_o = sub_i ? ~cin_i : cin_i;
    end
endmodule

// File: rtl/asf_carry_chain.sv
module asf_carry_chain
    import asf_pkg::*;
#(
    parameter int unsigned N = ASF_W
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         c0_i,
    output logic [N-1:0] sum_o,
    output logic [N:0]   carry_o
);
    assign carry_o[0] = c0_i;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic p;
        assign p              = a_i[i] ^ b_i[i];
        assign sum_o[i]       = p ^ carry_o[i];
        assign carry_o[i + 1] = (a_i[i] & b_i[i]) | (p & carry_o[i]);
    end
endmodule

// File: rtl/asf_flag_gen.sv
module asf_flag_gen
    import asf_pkg::*;
(
    input  logic [ASF_W-1:0] sum_i,
    input  logic [ASF_W:0]   carry_i,
    input  logic             sub_i,
    input  op_size_e         size_i,
    output logic [ASF_W-1:0] res_o,
    output flags_t           flags_o
);
    logic c_out, c_top_in, c_half, sign_bit;

    always_comb begin
        case (size_i)
            SZ_BYTE: begin
                c_out    = carry_i[BYTE_W];
                c_top_in = carry_i[BYTE_W-1];
                c_half   = carry_i[BYTE_W/2];
                sign_bit = sum_i[BYTE_W-1];
            end
            SZ_WORD: begin
                c_out    = carry_i[WORD_W];
                c_top_in = carry_i[WORD_W-1];
                c_half   = carry_i[WORD_W/2];
                sign_bit = sum_i[WORD_W-1];
            end
            default: begin
                c_out    = carry_i[ASF_W];
                c_top_in = carry_i[ASF_W-1];
                c_half   = carry_i[ASF_W/2];
                sign_bit = sum_i[ASF_W-1];
            end
        endcase

        res_o      = sum_i & width_mask(size_i);
        // a set adder carry on a subtract means no borrow happened
        flags_o.cf = c_out ^ sub_i;
        flags_o.af = c_half ^ sub_i;
        flags_o.of = c_out ^ c_top_in;
        flags_o.pf = ~^res_o;
        flags_o.zf = (res_o == '0);
        flags_o.sf = sign_bit;
    end
endmodule

// File: rtl/asf_unit.sv
module asf_unit
    import asf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ASF_W-1:0] opa_i,
    input  logic [ASF_W-1:0] opb_i,
    input  logic             cin_i,
    input  logic             sub_i,
    input  logic [1:0]       size_i,
    output logic [ASF_W-1:0] res_o,
    output logic             cf_o,
    output logic             pf_o,
    output logic             af_o,
    output logic             zf_o,
    output logic             sf_o,
    output logic             of_o
);
    typedef struct packed {
        logic [ASF_W-1:0] res;
        flags_t           fl;
    } out_t;

    localparam out_t RST_VAL = '{res: '0,
                                 fl: '{cf: 1'b0, pf: 1'b1, af: 1'b0,
                                       zf: 1'b1, sf: 1'b0, of: 1'b0}};

    op_size_e         size_e;
    logic [ASF_W-1:0] a_m, b_x, sum;
    logic [ASF_W:0]   carry;
    logic             c0;
    logic [ASF_W-1:0] res_c;
    flags_t           fl_c;
    out_t             out_d, out_q;

    assign size_e = op_size_e'(size_i);

    asf_operand_prep u_prep (
        .opa_i (opa_i),
        .opb_i (opb_i),
        .cin_i (cin_i),
        .sub_i (sub_i),
        .size_i(size_e),
        .a_o   (a_m),
        .b_o   (b_x),
        .c0_o  (c0)
    );

    asf_carry_chain #(.N(ASF_W)) u_chain (
        .a_i    (a_m),
        .b_i    (b_x),
        .c0_i   (c0),
        .sum_o  (sum),
        .carry_o(carry)
    );

    asf_flag_gen u_flags (
        .sum_i  (sum),
        .carry_i(carry),
        .sub_i  (sub_i),
        .size_i (size_e),
        .res_o  (res_c),
        .flags_o(fl_c)
    );

    always_comb begin
        out_d     = out_q;
        out_d.res = res_c;
        out_d.fl  = fl_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= RST_VAL;
        else        out_q <= out_d;
    end

    assign res_o = out_q.res;
    assign cf_o  = out_q.fl.cf;
    assign pf_o  = out_q.fl.pf;
    assign af_o  = out_q.fl.af;
    assign zf_o  = out_q.fl.zf;
    assign sf_o  = out_q.fl.sf;
    assign of_o  = out_q.fl.of;

    a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd0) |=> (res_o[ASF_W-1:BYTE_W] == '0));

    a_r3_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd1) |=> (res_o[ASF_W-1:WORD_W] == '0));

    a_r8_byte_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd0) |=> (sf_o == res_o[BYTE_W-1]));

    a_r7_zero_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (!sub_i && opa_i == '0 && opb_i == '0 && !cin_i)
        |=> (zf_o && pf_o && !cf_o && !of_o && res_o == '0));

    a_r4_no_borrow_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_i && opb_i == '0 && !cin_i) |=> !cf_o);

    a_r2_self_subtract: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_i && opa_i == opb_i && !cin_i) |=> (zf_o && !cf_o && !of_o));

    a_r9_mixed_sign_add: assert property (@(posedge clk) disable iff (!rst_n)
        (!sub_i && size_i[1] && opa_i[ASF_W-1] != opb_i[ASF_W-1]) |=> !of_o);

endmodule

// File: tb/asf_unit_test.sv
module asf_unit_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic        cin = 1'b0, sub = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [31:0] res;
    logic        cf, pf, af, zf, sf, of;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    asf_unit uut (
        .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb), .cin_i(cin),
        .sub_i(sub), .size_i(size), .res_o(res), .cf_o(cf), .pf_o(pf),
        .af_o(af), .zf_o(zf), .sf_o(sf), .of_o(of)
    );

    task automatic chk(string tag, longint unsigned got, longint unsigned exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h (a=%h b=%h cin=%0d sub=%0d size=%0d)",
                     tag, got, exp, opa, opb, cin, sub, size);
        end
    endtask

    // behavioural model: plain integer arithmetic at the selected width
    task automatic apply(logic [31:0] a, logic [31:0] b, logic ci, logic sb, logic [1:0] sz);
        int w, hw, ones;
        longint unsigned m, hm, am, bm, e_res;
        longint full, half, sa, sb_v, sr, lim;
        logic e_cf, e_af, e_of, e_pf, e_zf, e_sf;
        @(negedge clk);
        opa = a; opb = b; cin = ci; sub = sb; size = sz;
        w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        hw = w / 2;
        m  = (64'd1 << w) - 1;
        hm = (64'd1 << hw) - 1;
        am = longint'(a) & m;
        bm = longint'(b) & m;
        sa   = (am >> (w - 1)) != 0 ? longint'(am) - longint'(64'd1 << w) : longint'(am);
        sb_v = (bm >> (w - 1)) != 0 ? longint'(bm) - longint'(64'd1 << w) : longint'(bm);
        lim  = longint'(64'd1 << (w - 1));
        if (!sb) begin
            full = longint'(am) + longint'(bm) + longint'(ci);
            half = longint'(am & hm) + longint'(bm & hm) + longint'(ci);
            e_cf = ((full >> w) & 1) != 0;
            e_af = ((half >> hw) & 1) != 0;
            sr   = sa + sb_v + longint'(ci);
        end else begin
            full = longint'(am) - longint'(bm) - longint'(ci);
            half = longint'(am & hm) - longint'(bm & hm) - longint'(ci);
            e_cf = full < 0;
            e_af = half < 0;
            sr   = sa - sb_v - longint'(ci);
        end
        e_res = longint'(full) & m;
        e_of  = (sr >= lim) || (sr < -lim);
        ones  = 0;
        for (int i = 0; i < 32; i++) ones += int'((e_res >> i) & 1);
        e_pf = (ones % 2) == 0;
        e_zf = e_res == 0;
        e_sf = ((e_res >> (w - 1)) & 1) != 0;
        @(posedge clk);
        #1;
        chk(sb ? "R2 result sub" : "R1 result add", res & m, e_res);
        chk("R3 upper result bits", res & ~m, 0);
        chk("R4 carry/borrow", cf, e_cf);
        chk("R5 parity", pf, e_pf);
        chk("R6 aux carry", af, e_af);
        chk("R7 zero", zf, e_zf);
        chk("R8 sign", sf, e_sf);
        chk("R9 overflow", of, e_of);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset values
        chk("R10 reset res", res, 0);
        chk("R10 reset zf", zf, 1);
        chk("R10 reset pf", pf, 1);
        chk("R10 reset cf/af/sf/of", {cf, af, sf, of}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // byte corners
        apply(32'h0000_007F, 32'h0000_0001, 0, 0, 2'd0); // signed overflow, aux
        apply(32'h0000_00FF, 32'h0000_0001, 0, 0, 2'd0); // carry out, zero
        apply(32'h0000_0080, 32'h0000_0001, 0, 1, 2'd0); // signed overflow on sub
        apply(32'h0000_0000, 32'h0000_0001, 0, 1, 2'd0); // borrow
        apply(32'h0000_0010, 32'h0000_0001, 0, 1, 2'd0); // nibble borrow
        apply(32'h0000_0005, 32'h0000_0005, 1, 1, 2'd0); // borrow-in
        apply(32'hDEAD_BE0F, 32'h1234_5601, 1, 0, 2'd0); // R3 garbage ignored
        // word corners
        apply(32'h0000_00FF, 32'h0000_0001, 0, 0, 2'd1); // byte boundary carry
        apply(32'h0000_7FFF, 32'h0000_0001, 0, 0, 2'd1);
        apply(32'hABCD_0100, 32'hFFFF_0001, 0, 1, 2'd1); // R3 garbage, aux borrow
        apply(32'h0000_FFFF, 32'h0000_FFFF, 1, 0, 2'd1);
        // dword corners, both encodings
        apply(32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 2'd2);
        apply(32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 2'd3);
        apply(32'h8000_0000, 32'h0000_0001, 0, 1, 2'd2);
        apply(32'h0000_FFFF, 32'h0000_0001, 0, 0, 2'd3); // half-width carry
        apply(32'h0001_0000, 32'h0000_0001, 0, 1, 2'd2);
        apply(32'h0000_0000, 32'hFFFF_FFFF, 1, 1, 2'd2);
        apply(32'h0000_0000, 32'h0000_0000, 0, 0, 2'd2);

        for (int n = 0; n < 400; n++) begin
            apply($urandom, $urandom, 1'($urandom), 1'($urandom), 2'($urandom));
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule